// File: doc/BRIEF.md
# PWM Time Base with External Sync

This block is the primary time base for a PWM channel group. A 16-bit counter runs from zero up to an active period value and then starts over, so one PWM cycle lasts period+1 clocks. The active period is fed from a buffered period register. It is loaded either at once when software writes it, or only when a cycle ends. A cycle can also be ended early by an edge on one of two external sync inputs. The selected input is first corrected for polarity and then passed through a two-flop synchronizer. Each new cycle can be announced on a sync output pulse, and that pulse shares the input's polarity setting.

A special event compare value is matched against the counter. Each match advances a postscaler, and every (N+1)th match produces a one-clock trigger pulse. Each trigger sets a sticky status flag, which software clears. The interrupt line is the flag gated by an enable bit. Software programs the block through a control write strobe with one input per field, a period write port, a compare write port and a status clear strobe. A CPU idle input can stop the counter.

Top module: `pwm_timebase`

## Requirements
- R1: While the stored enable is 0 the counter reads 0 and the postscaler count is cleared. After the write that sets enable, the counter reads 0 in the following sample and then rises by one per clock.
- R2: When idle-stop is set and `cpu_idle` is high, the counter holds its value. When idle-stop is clear, `cpu_idle` has no effect on counting.
- R3: A running counter that is equal to or above the active period goes to 0 on the next clock, so with period P the count sequence is 0..P.
- R4: With immediate update set, a period write reaches `tb_period` on the same clock edge. With it clear, `tb_period` takes the buffered value only on the clock where a cycle ends. While disabled, `tb_period` follows the buffer.
- R5: Source code 0 selects `sync_in[0]` and code 1 selects `sync_in[1]`. Codes 2 and 3 select nothing, and no input then affects the counter.
- R6: With external sync enabled, the selected input turns active ahead of edge k and the counter reads 0 after edge k+2. Only the rising edge of the active level restarts the counter. A level that stays active does nothing, and neither does its release.
- R7: With the polarity bit set, the input is active-low (a falling pin edge restarts the counter). `sync_out` then rests at 1 and pulses to 0.
- R8: With sync output enabled, `sync_out` carries a one-clock pulse in the clock where the counter first reads 0 of a new cycle, whether that cycle began by wrap or by sync restart. No pulse is produced at enable.
- R9: For a postscaler value N, `sevt_trig` pulses for one clock, in the clock after the running counter equalled the compare value, on every (N+1)th such match.
- R10: A trigger sets `sevt_flag` on the same edge that raises `sevt_trig`. `stat_clr` clears the flag, and a trigger on the same edge wins. `sevt_irq` = flag AND interrupt enable.
- R11: While the stored enable is 1, a control write leaves the source, polarity, sync enable, sync output enable and postscaler fields unchanged. Enable, idle-stop, interrupt enable and immediate update still take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_idle | input | 1 | CPU idle indication |
| ctl_we | input | 1 | Control write strobe |
| ctl_enable | input | 1 | Time base enable |
| ctl_idle_stop | input | 1 | Halt counter while idle |
| ctl_irq_en | input | 1 | Special event interrupt enable |
| ctl_imm_per | input | 1 | Immediate period update |
| ctl_sync_pol | input | 1 | Sync polarity (1 = active-low) |
| ctl_sync_oe | input | 1 | Sync output enable |
| ctl_sync_en | input | 1 | External sync restart enable |
| ctl_sync_sel | input | 2 | Sync source code |
| ctl_post_sel | input | 4 | Postscaler value N |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | 16 | Period write data |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | 16 | Compare write data |
| stat_clr | input | 1 | Clear status flag |
| sync_in | input | 2 | External sync inputs |
| tb_count | output | 16 | Counter value |
| tb_period | output | 16 | Active period |
| sevt_trig | output | 1 | Postscaled trigger pulse |
| sevt_flag | output | 1 | Sticky status flag |
| sevt_irq | output | 1 | Interrupt request |
| sync_out | output | 1 | Cycle start pulse |

## Verification
The bench sweeps every postscaler value with a short period and computes each expected trigger position from the sample index. A postscaler count that survived a disable would shift the first trigger of the next run, and an off-by-one in the match count would place the pulses at the wrong positions. For every source code and both polarities, it checks that the restart lands exactly on the third edge and that a release or an unselected input causes no restart. Getting either wrong would show up as a count that keeps climbing, or as a restart one cycle off. It also covers a period buffered across a cycle, a clear on the same edge as a trigger, and control writes made while the block runs. A design that applied the period early, let the clear win, or took locked fields would show the wrong period, flag, pulse level or trigger rate.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

    localparam int POST_W = 4;
    localparam int SEL_W  = 2;

    typedef struct packed {
        logic enable;
        logic idle_stop;
        logic irq_en;
        logic imm_per;
    } run_cfg_t;

    typedef struct packed {
        logic              pol;
        logic              out_en;
        logic              ext_en;
        logic [SEL_W-1:0]  src;
        logic [POST_W-1:0] post;
    } sync_cfg_t;

    typedef enum logic [1:0] {
        CTR_CLEAR,
        CTR_HOLD,
        CTR_STEP,
        CTR_WRAP
    } ctr_step_e;

    function automatic ctr_step_e pick_step(logic en, logic halt, logic restart, logic at_end);
        if (!en)
            return CTR_CLEAR;
        else if (halt)
            return CTR_HOLD;
        else if (restart || at_end)
            return CTR_WRAP;
        else
            return CTR_STEP;
    endfunction

    function automatic logic apply_pol(logic lvl, logic pol);
        return lvl ^ pol;
    endfunction

endpackage

// File: rtl/pwm_sync_in.sv
module pwm_sync_in
    import pwm_tb_pkg::*;
#(
    parameter int NUM_SYNC = 2,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SYNC-1:0] sync_in,
    input  logic [SEL_W-1:0]    src,
    input  logic                pol,
    output logic                rise
);
    logic             lvl;
    logic             hit;
    logic [STAGES:0]  pipe;

    always_comb begin
        lvl = 1'b0;
        hit = 1'b0;
        for (int i = 0; i < NUM_SYNC; i++) begin
            if (src == SEL_W'(i)) begin
                lvl = apply_pol(sync_in[i], pol);
                hit = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            pipe <= '0;
        else
            pipe <= {pipe[STAGES-1:0], lvl};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !pipe[0]);

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             halt,
    input  logic             restart,
    input  logic             imm,
    input  logic             per_we,
    input  logic [CNT_W-1:0] per_wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] act_per,
    output logic             cyc_start,
    output logic             advancing
);
    localparam logic [CNT_W-1:0] PER_RST = '1;

    logic [CNT_W-1:0] per_buf;
    ctr_step_e        step;

    always_comb begin
        step = pick_step(en, halt, restart, count >= act_per);
    end

    assign cyc_start = (step == CTR_WRAP);
    assign advancing = (step == CTR_STEP) || (step == CTR_WRAP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (step)
                CTR_CLEAR: count <= '0;
                CTR_HOLD:  count <= count;
                CTR_STEP:  count <= count + 1'b1;
                default:   count <= '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            per_buf <= PER_RST;
        else if (per_we)
            per_buf <= per_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_per <= PER_RST;
        else if (imm && per_we)
            act_per <= per_wdata;
        else if (!en || cyc_start)
            act_per <= per_buf;
    end

    assert_hold_zero_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> count == '0);

    assert_idle_freeze_R2: assert property (@(posedge clk) disable iff (rst)
        (en && halt) |=> $stable(count));

    assert_wrap_end_R3: assert property (@(posedge clk) disable iff (rst)
        (en && !halt && count >= act_per) |=> count == '0);

    assert_buffered_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (en && !imm && !cyc_start) |=> $stable(act_per));

    assert_ext_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !halt && restart) |=> count == '0);

endmodule

// File: rtl/pwm_event_post.sv
module pwm_event_post
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              advancing,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  cmp,
    input  logic [POST_W-1:0] post_sel,
    input  logic              stat_clr,
    input  logic              irq_en,
    output logic              trig,
    output logic              flag,
    output logic              irq
);
    logic [POST_W-1:0] pcnt;
    logic              match;
    logic              fire;

    assign match = advancing && (count == cmp);
    assign fire  = match && (pcnt == post_sel);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (!en)
            pcnt <= '0;
        else if (match)
            pcnt <= fire ? '0 : pcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig <= 1'b0;
            flag <= 1'b0;
        end else begin
            trig <= fire;
            if (fire)
                flag <= 1'b1;
            else if (stat_clr)
                flag <= 1'b0;
        end
    end

    assign irq = flag & irq_en;

    assert_post_bound_R9: assert property (@(posedge clk) disable iff (rst)
        en |-> pcnt <= post_sel);

    assert_trig_sets_flag_R10: assert property (@(posedge clk) disable iff (rst)
        trig |-> flag);

    assert_clear_drops_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !fire) |=> !flag);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_SYNC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_idle,
    input  logic                ctl_we,
    input  logic                ctl_enable,
    input  logic                ctl_idle_stop,
    input  logic                ctl_irq_en,
    input  logic                ctl_imm_per,
    input  logic                ctl_sync_pol,
    input  logic                ctl_sync_oe,
    input  logic                ctl_sync_en,
    input  logic [SEL_W-1:0]    ctl_sync_sel,
    input  logic [POST_W-1:0]   ctl_post_sel,
    input  logic                per_we,
    input  logic [CNT_W-1:0]    per_wdata,
    input  logic                cmp_we,
    input  logic [CNT_W-1:0]    cmp_wdata,
    input  logic                stat_clr,
    input  logic [NUM_SYNC-1:0] sync_in,
    output logic [CNT_W-1:0]    tb_count,
    output logic [CNT_W-1:0]    tb_period,
    output logic                sevt_trig,
    output logic                sevt_flag,
    output logic                sevt_irq,
    output logic                sync_out
);
    run_cfg_t         run_q;
    sync_cfg_t        sync_q;
    logic [CNT_W-1:0] cmp_q;
    logic             halt;
    logic             rise;
    logic             restart;
    logic             cyc_start;
    logic             advancing;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            sync_q <= '0;
        end else if (ctl_we) begin
            run_q <= '{enable: ctl_enable, idle_stop: ctl_idle_stop,
                       irq_en: ctl_irq_en, imm_per: ctl_imm_per};
            if (!run_q.enable)
                sync_q <= '{pol: ctl_sync_pol, out_en: ctl_sync_oe, ext_en: ctl_sync_en,
                            src: ctl_sync_sel, post: ctl_post_sel};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= '0;
        else if (cmp_we)
            cmp_q <= cmp_wdata;
    end

    assign halt    = run_q.idle_stop & cpu_idle;
    assign restart = rise & sync_q.ext_en;

    pwm_sync_in #(
        .NUM_SYNC (NUM_SYNC),
        .STAGES   (SYNC_STAGES)
    ) u_sync_in (
        .clk     (clk),
        .rst     (rst),
        .sync_in (sync_in),
        .src     (sync_q.src),
        .pol     (sync_q.pol),
        .rise    (rise)
    );

    pwm_period_ctr #(
        .CNT_W (CNT_W)
    ) u_period_ctr (
        .clk       (clk),
        .rst       (rst),
        .en        (run_q.enable),
        .halt      (halt),
        .restart   (restart),
        .imm       (run_q.imm_per),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .count     (tb_count),
        .act_per   (tb_period),
        .cyc_start (cyc_start),
        .advancing (advancing)
    );

    pwm_event_post #(
        .CNT_W (CNT_W)
    ) u_event_post (
        .clk       (clk),
        .rst       (rst),
        .en        (run_q.enable),
        .advancing (advancing),
        .count     (tb_count),
        .cmp       (cmp_q),
        .post_sel  (sync_q.post),
        .stat_clr  (stat_clr),
        .irq_en    (run_q.irq_en),
        .trig      (sevt_trig),
        .flag      (sevt_flag),
        .irq       (sevt_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pulse_q <= 1'b0;
        else
            pulse_q <= cyc_start & sync_q.out_en;
    end

    assign sync_out = pulse_q ^ sync_q.pol;

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (run_q.enable && ctl_we) |=> $stable(sync_q));

    assert_pulse_at_zero_R8: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> tb_count == '0);

endmodule

// File: tb/pwm_timebase_bench.sv
module pwm_timebase_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_idle, ctl_we;
    logic        ctl_enable, ctl_idle_stop, ctl_irq_en, ctl_imm_per;
    logic        ctl_sync_pol, ctl_sync_oe, ctl_sync_en;
    logic [1:0]  ctl_sync_sel;
    logic [3:0]  ctl_post_sel;
    logic        per_we, cmp_we, stat_clr;
    logic [15:0] per_wdata, cmp_wdata;
    logic [1:0]  sync_in;
    logic [15:0] tb_count, tb_period;
    logic        sevt_trig, sevt_flag, sevt_irq, sync_out;

    bit en_v, is_v, ie_v, im_v, pol_v, oe_v, se_v;
    bit [1:0] sel_v;
    bit [3:0] post_v;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_timebase u_pwm_timebase (
        .clk(clk), .rst(rst), .cpu_idle(cpu_idle), .ctl_we(ctl_we),
        .ctl_enable(ctl_enable), .ctl_idle_stop(ctl_idle_stop), .ctl_irq_en(ctl_irq_en),
        .ctl_imm_per(ctl_imm_per), .ctl_sync_pol(ctl_sync_pol), .ctl_sync_oe(ctl_sync_oe),
        .ctl_sync_en(ctl_sync_en), .ctl_sync_sel(ctl_sync_sel), .ctl_post_sel(ctl_post_sel),
        .per_we(per_we), .per_wdata(per_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .stat_clr(stat_clr), .sync_in(sync_in), .tb_count(tb_count), .tb_period(tb_period),
        .sevt_trig(sevt_trig), .sevt_flag(sevt_flag), .sevt_irq(sevt_irq), .sync_out(sync_out)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic put_ctl();
        ctl_enable = en_v; ctl_idle_stop = is_v; ctl_irq_en = ie_v; ctl_imm_per = im_v;
        ctl_sync_pol = pol_v; ctl_sync_oe = oe_v; ctl_sync_en = se_v;
        ctl_sync_sel = sel_v; ctl_post_sel = post_v;
        ctl_we = 1'b1;
        tick(1);
        ctl_we = 1'b0;
    endtask

    task automatic write_per(input int v);
        per_wdata = 16'(v); per_we = 1'b1;
        tick(1);
        per_we = 1'b0;
    endtask

    task automatic write_cmp(input int v);
        cmp_wdata = 16'(v); cmp_we = 1'b1;
        tick(1);
        cmp_we = 1'b0;
    endtask

    task automatic clear_flag();
        stat_clr = 1'b1;
        tick(1);
        stat_clr = 1'b0;
    endtask

    // disable, then write the fields while disabled; leaves the block off
    task automatic reprogram();
        en_v = 1'b0;
        put_ctl();
        put_ctl();
        tick(3);
    endtask

    task automatic go();
        en_v = 1'b1;
        put_ctl();
    endtask

    // drive one sync input to its active level and follow the counter
    task automatic pulse_chk(input int idx, input bit act_lvl, input bit exp_rs,
                             input bit pol, input int pv, input string tag);
        int c0;
        c0 = int'(tb_count);
        sync_in[idx] = act_lvl;
        tick(1);
        chk({tag, " count+1"}, int'(tb_count), (c0 + 1) % (pv + 1));
        tick(1);
        chk({tag, " count+2"}, int'(tb_count), (c0 + 2) % (pv + 1));
        tick(1);
        chk({tag, " third edge"}, int'(tb_count), exp_rs ? 0 : (c0 + 3) % (pv + 1));
        if (exp_rs)
            chk({tag, " R8 sync_out at restart"}, int'(sync_out), int'(!pol));
        sync_in[idx] = !act_lvl;
        tick(4);
        chk({tag, " release ignored"}, int'(tb_count), exp_rs ? 4 : (c0 + 7) % (pv + 1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c0;
        int errs;
        int ntrig;
        rst = 1'b1; cpu_idle = 1'b0; ctl_we = 1'b0; per_we = 1'b0; cmp_we = 1'b0;
        stat_clr = 1'b0; per_wdata = '0; cmp_wdata = '0; sync_in = '0;
        {en_v, is_v, ie_v, im_v, pol_v, oe_v, se_v} = '0;
        sel_v = '0; post_v = '0;
        ctl_enable = 0; ctl_idle_stop = 0; ctl_irq_en = 0; ctl_imm_per = 0;
        ctl_sync_pol = 0; ctl_sync_oe = 0; ctl_sync_en = 0; ctl_sync_sel = 0; ctl_post_sel = 0;
        tick(3);
        rst = 1'b0;

        chk("R1 reset count", int'(tb_count), 0);
        chk("R4 reset period", int'(tb_period), 65535);
        chk("R9 reset trig", int'(sevt_trig), 0);
        chk("R10 reset flag", int'(sevt_flag), 0);
        chk("R10 reset irq", int'(sevt_irq), 0);
        chk("R8 reset sync_out", int'(sync_out), 0);
        tick(5);
        chk("R1 disabled holds zero", int'(tb_count), 0);

        write_per(9);
        tick(2);
        chk("R4 disabled period follows buffer", int'(tb_period), 9);

        // R1 R3 R8: count sequence and sync pulses with period 9
        oe_v = 1'b1;
        go();
        for (int j = 0; j < 35; j++) begin
            chk("R3 count sequence", int'(tb_count), j % 10);
            chk("R8 sync_out pulse", int'(sync_out), int'(j > 0 && j % 10 == 0));
            tick(1);
        end

        // R2 idle stop
        is_v = 1'b1;
        put_ctl();
        c0 = int'(tb_count);
        cpu_idle = 1'b1;
        tick(4);
        chk("R2 halted in idle", int'(tb_count), c0);
        cpu_idle = 1'b0;
        tick(1);
        chk("R2 resumes after idle", int'(tb_count), (c0 + 1) % 10);
        is_v = 1'b0;
        put_ctl();
        c0 = int'(tb_count);
        cpu_idle = 1'b1;
        tick(3);
        chk("R2 runs in idle when not stopped", int'(tb_count), (c0 + 3) % 10);
        cpu_idle = 1'b0;

        // R4 buffered update
        while (tb_count != 16'd2) tick(1);
        write_per(4);
        chk("R4 buffered period unchanged", int'(tb_period), 9);
        while (tb_count != 16'd9) tick(1);
        chk("R4 old period up to boundary", int'(tb_period), 9);
        tick(1);
        chk("R4 wrap at old period", int'(tb_count), 0);
        chk("R4 new period at boundary", int'(tb_period), 4);
        tick(4);
        chk("R3 count at new period", int'(tb_count), 4);
        tick(1);
        chk("R3 wrap at new period", int'(tb_count), 0);

        // R4 immediate update
        im_v = 1'b1;
        put_ctl();
        write_per(20);
        chk("R4 immediate period", int'(tb_period), 20);
        tick(2);
        chk("R4 count at 4", int'(tb_count), 4);
        tick(1);
        chk("R4 no wrap at old period", int'(tb_count), 5);
        im_v = 1'b0;
        put_ctl();

        // R5 R6 sync with source 0
        se_v = 1'b1; sel_v = 2'd0;
        reprogram();
        write_per(200);
        tick(2);
        go();
        tick(20);
        pulse_chk(0, 1'b1, 1'b1, 1'b0, 200, "R6 src0 input0 restart");
        pulse_chk(1, 1'b1, 1'b0, 1'b0, 200, "R5 src0 input1 ignored");

        sel_v = 2'd1;
        reprogram();
        go();
        tick(10);
        pulse_chk(0, 1'b1, 1'b0, 1'b0, 200, "R5 src1 input0 ignored");
        pulse_chk(1, 1'b1, 1'b1, 1'b0, 200, "R5 R6 src1 input1 restart");

        sel_v = 2'd2;
        reprogram();
        go();
        tick(5);
        pulse_chk(0, 1'b1, 1'b0, 1'b0, 200, "R5 src2 input0 none");
        pulse_chk(1, 1'b1, 1'b0, 1'b0, 200, "R5 src2 input1 none");

        sel_v = 2'd3;
        reprogram();
        go();
        tick(5);
        pulse_chk(1, 1'b1, 1'b0, 1'b0, 200, "R5 src3 input1 none");

        // R7 active-low
        sync_in = 2'b11;
        pol_v = 1'b1; sel_v = 2'd0;
        reprogram();
        go();
        tick(5);
        chk("R7 sync_out idles high", int'(sync_out), 1);
        pulse_chk(0, 1'b0, 1'b1, 1'b1, 200, "R7 falling pin edge restart");

        // R9 postscaler sweep, period 7, compare 3
        sync_in = 2'b00;
        pol_v = 1'b0; se_v = 1'b0; oe_v = 1'b0;
        for (int n = 0; n < 16; n++) begin
            post_v = 4'(n);
            reprogram();
            write_per(7);
            write_cmp(3);
            clear_flag();
            go();
            errs = 0;
            for (int j = 0; j < 16 * (n + 1); j++) begin
                if (int'(sevt_trig) != int'((j % 8 == 4) && (((j / 8) + 1) % (n + 1) == 0)))
                    errs++;
                tick(1);
            end
            chk($sformatf("R9 trigger positions N=%0d", n), errs, 0);
            chk("R10 flag set by trigger", int'(sevt_flag), 1);
            chk("R10 irq masked", int'(sevt_irq), 0);
        end

        // R10 flag clear, irq, set-wins
        clear_flag();
        chk("R10 flag cleared", int'(sevt_flag), 0);
        post_v = 4'd0; ie_v = 1'b1; se_v = 1'b1; sel_v = 2'd0; oe_v = 1'b1; pol_v = 1'b0;
        reprogram();
        go();
        tick(4);
        chk("R9 trig N=0", int'(sevt_trig), 1);
        chk("R10 irq follows flag", int'(sevt_irq), 1);
        clear_flag();
        chk("R10 clear flag", int'(sevt_flag), 0);
        chk("R10 clear irq", int'(sevt_irq), 0);
        tick(6);
        chk("R9 count at compare", int'(tb_count), 3);
        stat_clr = 1'b1;
        tick(1);
        stat_clr = 1'b0;
        chk("R10 set wins over clear", int'(sevt_flag), 1);
        chk("R10 irq after set-wins", int'(sevt_irq), 1);

        // R11 locked fields while enabled
        sel_v = 2'd2; post_v = 4'd3; oe_v = 1'b0; pol_v = 1'b1; se_v = 1'b0; ie_v = 1'b0;
        put_ctl();
        chk("R11 irq enable still writable", int'(sevt_irq), 0);
        chk("R11 flag kept", int'(sevt_flag), 1);
        chk("R11 polarity kept", int'(sync_out), 0);
        tick(3);
        chk("R11 count wrapped", int'(tb_count), 0);
        chk("R11 output enable kept", int'(sync_out), 1);
        ntrig = 0;
        for (int j = 0; j < 16; j++) begin
            if (sevt_trig) ntrig++;
            tick(1);
        end
        chk("R11 postscaler kept", ntrig, 2);
        pulse_chk(0, 1'b1, 1'b1, 1'b0, 7, "R11 sync source kept");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule